// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator with End-of-Interrupt Re-arm

This block gathers two groups of event lines, endpoint events and core events, into latched source registers on a simple single-cycle 32-bit register bus. Each group has a mask register and a masked view. Each source and each mask has a write-one-to-set alias and a write-one-to-clear alias, so software can force an event or drop one without a read-modify-write. One interrupt line goes to the processor. It is raised when the block is armed and any masked bit in either group is set. The block disarms as soon as it fires and stays quiet until software writes the end-of-interrupt register.

The arming logic is a three-state machine. In `ST_ARMED` the line is low and the block waits for a masked event; a pending masked bit moves it to `ST_FIRE`. In `ST_FIRE` the line is high for exactly one cycle. It moves to `ST_WAIT_EOI`, or back to `ST_ARMED` if an end-of-interrupt write lands in that same cycle. In `ST_WAIT_EOI` the line is low and new events only latch. An end-of-interrupt write moves it to `ST_ARMED`. A soft reset from any state returns the machine to `ST_ARMED`.

The block also has a fixed nonzero revision word, a status word and a self-clearing soft-reset bit. Bus reads are combinational: `bus_rdata` is valid in the cycle that `bus_sel` is high and `bus_we` is low, and it is zero at all other times.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every source, mask and masked word reads 0, `irq` is low, and offset 0x00 reads the nonzero parameter `REV_ID`.
- R2: The endpoint group keeps only bits 0–15 (transmit endpoints 0–15) and bits 17–31 (receive endpoints 1–15). Bit 16 always reads 0. The source is read at 0x20, source-set is 0x24 and source-clear is 0x28.
- R3: The core group keeps only bits 16–24. All other bits read 0. The source is read at 0x40, source-set is 0x44 and source-clear is 0x48.
- R4: Writing ones to a clear alias clears those source or mask bits. Writing ones to mask-set (0x30 endpoint, 0x50 core) enables mask bits. Mask-clear is at 0x34 and 0x54. Masks are read at 0x2c and 0x4c.
- R5: The masked word (0x38 endpoint, 0x58 core) reads as source AND mask.
- R6: An input event pulse latches its source bit. Transmit lane i maps to endpoint bit i, receive lane j to endpoint bit 17+j, and core lane k to core bit 16+k. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: `irq` is high for exactly one cycle. It rises in the second cycle after the write or event that makes a masked bit pending while the block is armed. Unmasked sources never raise it.
- R8: After firing, `irq` stays low whatever is pending until any value is written to 0x60. If a masked bit is still pending after that write, `irq` rises again in the second cycle after it.
- R9: Writing 1 to bit 0 of 0x04 sets a soft-reset bit that reads 1 for one cycle and then clears itself. At the same time all sources and masks clear and the block returns to the armed state.
- R10: Reads of 0x10, 0x5c, every set or clear alias, and unmapped offsets return 0. Writes to 0x10, 0x5c, unmapped offsets and the plain source and mask offsets (0x20, 0x2c, 0x40, 0x4c) have no effect.
- R11: Bit 0 of the status word at 0x08 reads 1 in the armed state and 0 otherwise. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle, zero otherwise |
| ep_tx_evt | input | EP_TX_N (16) | Transmit endpoint event pulses |
| ep_rx_evt | input | EP_RX_N (15) | Receive endpoint event pulses, endpoints 1 and up |
| core_evt | input | CORE_N (9) | Core event pulses |
| irq | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with its default parameters: 16 transmit lanes, 15 receive lanes, and 9 core lanes starting at bit 16. With these values both 32-bit groups are exercised in full. The bench walks a single one through all 32 positions of each group's set and clear aliases, and pulses every event lane alone. Each result is compared with valid-bit masks that the bench computes by shifting. The firing, end-of-interrupt and soft-reset sequences are timed edge by edge through the three machine states.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned N_GRP  = 2;

    localparam logic [ADDR_W-1:0] OFF_REV   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_EPG   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CORG  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_EOI   = 8'h60;

    // Offsets inside one group, relative to its base
    localparam logic [ADDR_W-1:0] REL_SRC     = 8'h00;
    localparam logic [ADDR_W-1:0] REL_SRC_SET = 8'h04;
    localparam logic [ADDR_W-1:0] REL_SRC_CLR = 8'h08;
    localparam logic [ADDR_W-1:0] REL_MSK     = 8'h0c;
    localparam logic [ADDR_W-1:0] REL_MSK_SET = 8'h10;
    localparam logic [ADDR_W-1:0] REL_MSK_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] REL_MASKED  = 8'h18;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_FIRE     = 2'd1,
        ST_WAIT_EOI = 2'd2
    } arm_state_e;

    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_set;
        logic msk_clr;
    } grp_wr_t;

    function automatic logic [DATA_W-1:0] ones_lo(input int unsigned n);
        if (n == 0) return '0;
        return {DATA_W{1'b1}} >> (DATA_W - n);
    endfunction

endpackage

// File: rtl/irqhub_group.sv
module irqhub_group
    import irqhub_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = {DATA_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic [DATA_W-1:0] evt,
    input  grp_wr_t           wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] src_q,
    output logic [DATA_W-1:0] msk_q,
    output logic [DATA_W-1:0] pend
);

    logic [DATA_W-1:0] src_d, msk_d;

    always_comb begin
        // hardware events are ORed in after the clear, so an event wins
        src_d = ((src_q & ~(wr.src_clr ? wdata : '0))
                 | (wr.src_set ? wdata : '0)
                 | evt) & VALID;
        msk_d = ((msk_q & ~(wr.msk_clr ? wdata : '0))
                 | (wr.msk_set ? wdata : '0)) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            msk_q <= '0;
        end else if (clr_all) begin
            src_q <= '0;
            msk_q <= '0;
        end else begin
            src_q <= src_d;
            msk_q <= msk_d;
        end
    end

    assign pend = src_q & msk_q;

endmodule

// File: rtl/irqhub_arm.sv
module irqhub_arm
    import irqhub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all,
    input  logic pend_any,
    input  logic eoi,
    output logic irq,
    output logic armed
);

    arm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_all) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_ARMED:    if (pend_any) state_d = ST_FIRE;
                ST_FIRE:     state_d = eoi ? ST_ARMED : ST_WAIT_EOI;
                ST_WAIT_EOI: if (eoi) state_d = ST_ARMED;
                default:     state_d = ST_ARMED;
            endcase
        end
    end

    always_comb begin
        irq   = (state_q == ST_FIRE);
        armed = (state_q == ST_ARMED);
    end

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import irqhub_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_ID   = 32'h0002_0103,
    parameter int unsigned       EP_TX_N  = 16,
    parameter int unsigned       EP_RX_N  = 15,
    parameter int unsigned       CORE_N   = 9,
    parameter int unsigned       CORE_LSB = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [EP_TX_N-1:0]  ep_tx_evt,
    input  logic [EP_RX_N-1:0]  ep_rx_evt,
    input  logic [CORE_N-1:0]   core_evt,
    output logic                irq
);

    localparam int unsigned       EP_RX_LSB  = DATA_W - EP_RX_N;
    localparam logic [DATA_W-1:0] EP_VALID   = ones_lo(EP_TX_N) | (ones_lo(EP_RX_N) << EP_RX_LSB);
    localparam logic [DATA_W-1:0] CORE_VALID = ones_lo(CORE_N) << CORE_LSB;

    logic wr_en, rd_en, eoi_wr, soft_q, armed, pend_any;
    logic [N_GRP-1:0][DATA_W-1:0] evt_w, src_w, msk_w, pend_w, grp_rd;
    grp_wr_t wr_w [N_GRP];
    logic [DATA_W-1:0] rd_word;

    assign wr_en  = bus_sel & bus_we;
    assign rd_en  = bus_sel & ~bus_we;
    assign eoi_wr = wr_en && (bus_addr == OFF_EOI);

    assign evt_w[0] = DATA_W'(ep_tx_evt) | (DATA_W'(ep_rx_evt) << EP_RX_LSB);
    assign evt_w[1] = DATA_W'(core_evt) << CORE_LSB;

    // soft reset: one-cycle pulse, further control writes ignored while it is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                soft_q <= 1'b0;
        else if (soft_q)                           soft_q <= 1'b0;
        else if (wr_en && bus_addr == OFF_CTRL)    soft_q <= bus_wdata[0];
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] GB = (g == 0) ? OFF_EPG : OFF_CORG;
        localparam logic [DATA_W-1:0] GV = (g == 0) ? EP_VALID : CORE_VALID;

        assign wr_w[g].src_set = wr_en && (bus_addr == GB + REL_SRC_SET);
        assign wr_w[g].src_clr = wr_en && (bus_addr == GB + REL_SRC_CLR);
        assign wr_w[g].msk_set = wr_en && (bus_addr == GB + REL_MSK_SET);
        assign wr_w[g].msk_clr = wr_en && (bus_addr == GB + REL_MSK_CLR);

        irqhub_group #(.VALID(GV)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_all (soft_q),
            .evt     (evt_w[g]),
            .wr      (wr_w[g]),
            .wdata   (bus_wdata),
            .src_q   (src_w[g]),
            .msk_q   (msk_w[g]),
            .pend    (pend_w[g])
        );

        assign grp_rd[g] = (bus_addr == GB + REL_SRC)    ? src_w[g]  :
                           (bus_addr == GB + REL_MSK)    ? msk_w[g]  :
                           (bus_addr == GB + REL_MASKED) ? pend_w[g] : '0;
    end

    assign pend_any = |pend_w;

    irqhub_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (soft_q),
        .pend_any (pend_any),
        .eoi      (eoi_wr),
        .irq      (irq),
        .armed    (armed)
    );

    always_comb begin
        case (bus_addr)
            OFF_REV:  rd_word = REV_ID;
            OFF_CTRL: rd_word = {{(DATA_W-1){1'b0}}, soft_q};
            OFF_STAT: rd_word = {{(DATA_W-1){1'b0}}, armed};
            default:  rd_word = grp_rd[0] | grp_rd[1];
        endcase
    end

    assign bus_rdata = rd_en ? rd_word : '0;

endmodule

// File: rtl/irqhub_chk.sv
module irqhub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        armed,
    input logic        soft_q,
    input logic        eoi_wr,
    input logic        pend_any,
    input logic [31:0] ep_evt,
    input logic [31:0] ep_src,
    input logic [31:0] ep_msk,
    input logic [31:0] core_msk
);

    p_event_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ep_evt && !soft_q) |=> ((ep_src & $past(ep_evt)) == $past(ep_evt)));

    p_fire_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pend_any));

    p_one_cycle_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_quiet_until_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !irq && !eoi_wr) |=> !irq);

    p_eoi_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !armed) |=> armed);

    p_soft_clears_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> (ep_msk == 32'h0 && core_msk == 32'h0 && armed));

    p_soft_self_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> !soft_q);

endmodule

bind evt_irq_hub irqhub_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .armed    (armed),
    .soft_q   (soft_q),
    .eoi_wr   (eoi_wr),
    .pend_any (pend_any),
    .ep_evt   (evt_w[0]),
    .ep_src   (src_w[0]),
    .ep_msk   (msk_w[0]),
    .core_msk (msk_w[1])
);

// File: tb/evt_irq_hub_tb.sv
`timescale 1ns/1ps
module evt_irq_hub_tb;

    localparam logic [31:0] REV    = 32'h0002_0103;
    localparam logic [31:0] EP_V   = ((32'h1 << 16) - 1) | (((32'h1 << 15) - 1) << 17);
    localparam logic [31:0] CORE_V = ((32'h1 << 9) - 1) << 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] ep_tx_evt = '0;
    logic [14:0] ep_rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int irq_highs = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    evt_irq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_tx_evt(ep_tx_evt), .ep_rx_evt(ep_rx_evt), .core_evt(core_evt),
        .irq(irq)
    );

    always @(posedge clk) if (irq) irq_highs++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    task automatic cleanup();
        wr(8'h28, '1); wr(8'h34, '1); wr(8'h48, '1); wr(8'h54, '1);
        wr(8'h60, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R1 rev", v, REV);
        chk("R1 rev nonzero", {31'b0, (REV != 0)}, 32'h1);
        foreach (u_dummy[i]) ;
        for (int a = 0; a < 7; a++) begin
            rd(8'h20 + 8'(a * 4), v); chk("R1 ep word", (a == 1 || a == 2 || a == 4 || a == 5) ? 32'h0 : v, 32'h0);
            rd(8'h40 + 8'(a * 4), v); chk("R1 core word", v, 32'h0);
        end
        rd(8'h08, v); chk("R11 status armed", v, 32'h1);

        // R2/R3/R4 walking one through set and clear aliases
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < 32; b++) begin
                logic [7:0]  base;
                logic [31:0] vm;
                base = (g == 0) ? 8'h20 : 8'h40;
                vm   = (g == 0) ? EP_V : CORE_V;
                wr(base + 8'h04, 32'h1 << b);
                rd(base, v);
                chk(g == 0 ? "R2 ep set" : "R3 core set", v, (32'h1 << b) & vm);
                wr(base + 8'h08, 32'h1 << b);
                rd(base, v);
                chk("R4 src clear", v, 32'h0);
            end
        end
        chk("R7 no irq unmasked", irq_highs, 0);

        // R4 masks, R5 masked view
        for (int g = 0; g < 2; g++) begin
            logic [7:0]  base;
            logic [31:0] vm;
            base = (g == 0) ? 8'h20 : 8'h40;
            vm   = (g == 0) ? EP_V : CORE_V;
            wr(base + 8'h10, '1);
            rd(base + 8'h0c, v); chk("R4 mask set", v, vm);
            wr(base + 8'h14, 32'h5555_5555);
            rd(base + 8'h0c, v); chk("R4 mask clear", v, vm & ~32'h5555_5555);
            wr(base + 8'h04, 32'h0F0F_0F0F);
            rd(base + 8'h18, v); chk("R5 masked", v, vm & ~32'h5555_5555 & 32'h0F0F_0F0F);
        end
        cleanup();

        // R6 every event lane alone
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); ep_tx_evt = 16'h1 << i;
            @(negedge clk); ep_tx_evt = '0;
            rd_now(8'h20, v); chk("R6 tx lane", v, 32'h1 << i);
            wr(8'h28, '1);
        end
        for (int j = 0; j < 15; j++) begin
            @(negedge clk); ep_rx_evt = 15'h1 << j;
            @(negedge clk); ep_rx_evt = '0;
            rd_now(8'h20, v); chk("R6 rx lane", v, 32'h1 << (17 + j));
            wr(8'h28, '1);
        end
        for (int k = 0; k < 9; k++) begin
            @(negedge clk); core_evt = 9'h1 << k;
            @(negedge clk); core_evt = '0;
            rd_now(8'h40, v); chk("R6 core lane", v, 32'h1 << (16 + k));
            wr(8'h48, '1);
        end

        // R6 event wins over a same-cycle clear
        wr(8'h24, 32'h18);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h18;
        ep_tx_evt = 16'h8;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; ep_tx_evt = '0;
        rd(8'h20, v); chk("R6 event beats clear", v, 32'h8);
        cleanup();

        // R7 firing timing, R11 status
        wr(8'h30, 32'h4);
        wr(8'h24, 32'h4);
        @(negedge clk); chk("R7 not yet", {31'b0, irq}, 32'h0);
        rd_now(8'h08, v); chk("R11 armed before fire", v, 32'h1);
        @(negedge clk); chk("R7 fires", {31'b0, irq}, 32'h1);
        rd_now(8'h08, v); chk("R11 disarmed in fire", v, 32'h0);
        @(negedge clk); chk("R7 one cycle", {31'b0, irq}, 32'h0);
        rd_now(8'h08, v); chk("R11 disarmed waiting", v, 32'h0);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk); chk("R8 quiet without eoi", {31'b0, irq}, 32'h0);
        end

        // R8 end-of-interrupt re-arm with bit still pending
        wr(8'h60, 32'hDEAD_BEEF);
        @(negedge clk); chk("R8 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk); chk("R8 refires", {31'b0, irq}, 32'h1);
        wr(8'h28, 32'h4);
        wr(8'h60, 32'h0);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk); chk("R8 nothing pending", {31'b0, irq}, 32'h0);
        end
        rd_now(8'h08, v); chk("R11 armed after eoi", v, 32'h1);

        // R9 soft reset
        wr(8'h50, 32'h1_0000);
        wr(8'h44, 32'h1_0000);
        repeat (3) @(negedge clk);
        wr(8'h04, 32'h1);
        @(negedge clk); rd_now(8'h04, v); chk("R9 ctrl high", v, 32'h1);
        @(negedge clk); rd_now(8'h04, v); chk("R9 ctrl self clear", v, 32'h0);
        rd_now(8'h08, v); chk("R9 armed", v, 32'h1);
        rd(8'h40, v); chk("R9 core src", v, 32'h0);
        rd(8'h4c, v); chk("R9 core mask", v, 32'h0);
        rd(8'h2c, v); chk("R9 ep mask", v, 32'h0);
        rd(8'h20, v); chk("R9 ep src", v, 32'h0);
        wr(8'h30, 32'h1);
        wr(8'h24, 32'h1);
        @(negedge clk); chk("R9 rearm wait", {31'b0, irq}, 32'h0);
        @(negedge clk); chk("R9 fires without eoi", {31'b0, irq}, 32'h1);
        cleanup();

        // R10 reserved offsets and read-only words
        irq_highs = 0;
        wr(8'h10, '1); wr(8'h5c, '1); wr(8'h7c, '1);
        wr(8'h20, '1); wr(8'h2c, '1); wr(8'h40, '1); wr(8'h4c, '1);
        rd(8'h10, v); chk("R10 0x10", v, 32'h0);
        rd(8'h5c, v); chk("R10 0x5c", v, 32'h0);
        rd(8'h7c, v); chk("R10 unmapped", v, 32'h0);
        rd(8'h20, v); chk("R10 ep src", v, 32'h0);
        rd(8'h2c, v); chk("R10 ep mask", v, 32'h0);
        rd(8'h40, v); chk("R10 core src", v, 32'h0);
        rd(8'h4c, v); chk("R10 core mask", v, 32'h0);
        wr(8'h24, 32'h2);
        rd(8'h24, v); chk("R10 alias reads zero", v, 32'h0);
        rd(8'h20, v); chk("R10 set alias works", v, 32'h2);
        chk("R10 no irq", irq_highs, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    logic u_dummy [1];

endmodule